// File: doc/BRIEF.md
# Two-Wire Bus Hang Recovery Sequencer

This block frees a two-wire (I2C) bus that a target device has left stuck, typically because the target was interrupted in the middle of sending a byte and still holds the data line low. The block controls both bus lines through open-drain pull-down enables and reads both lines back through two-flop synchronizers. A pull enable of 1 drives its line low, and 0 leaves it to the pull-up. A one-cycle start request launches a run, which has three phases:

1. Release both lines, then wait, polling coarsely and with a long limit, for any clock stretching to end.
2. Clock the bus until the target lets go of the data line.
3. Issue a bare START followed by a STOP, so that any target part-way through a transfer is reset.

Every run ends with a single-cycle `done` pulse. The `bus_err` flag beside it tells success (0) from failure (1). Both failure causes give the same flag:

- the clock line never rose within the limit;
- the data line was still low after the maximum number of recovery clocks.

All delays come from a cycles-per-microsecond parameter, so a simulation build can shorten them. For correct sampling, the half-period `HALF_US*CYC_PER_US` must be at least 3 cycles, which covers the synchronizer latency.

Top module: `bus_unstick`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull`, `busy`, `done` and `bus_err` are all 0.
- R2: A `start` pulse while idle raises `busy` in the next cycle. During the clock-wait phase both pull enables stay 0.
- R3: The synchronized clock line is sampled once at the start of the wait phase and again every `POLL_US` microseconds, up to ceil(`LIMIT_US`/`POLL_US`) samples in all. If every sample reads low, the run ends with `bus_err`=1 about `(samples-1)*POLL_US` microseconds after the start. No recovery clock or START is issued in that case.
- R4: If the clock line reads high at any poll sample before the limit, the run moves on to the data-line phase.
- R5: The data line is checked before each recovery clock. When it reads high, clocking stops, so the number of pulses equals the number of clocks the target needed to release the data line.
- R6: Each recovery clock holds `scl_pull`=1 for exactly `HALF_US*CYC_PER_US` cycles, then releases the clock line for the same time.
- R7: At most `MAX_PULSES` (default 9) recovery clocks are issued. If the data line is still low at the check after the last one, the run ends with `bus_err`=1 and `sda_pull` is never asserted.
- R8: On a successful run, `sda_pull` is 1 for exactly `HALF_US*CYC_PER_US` cycles while `scl_pull` is 0 (START). It is then released for the same time (STOP), after which `done` is raised with `bus_err`=0.
- R9: `done` is high for exactly one cycle per run, with `busy`=0 in that cycle. `bus_err` is valid in that cycle and holds its value until the next run is accepted.
- R10: A `start` pulse while `busy` is 1 has no effect. The run in progress ends at the same time and with the same result, and only one `done` is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a recovery run |
| scl_in | input | 1 | Clock line level as read from the pad (asynchronous) |
| sda_in | input | 1 | Data line level as read from the pad (asynchronous) |
| scl_pull | output | 1 | 1 = drive the clock line low, 0 = release it |
| sda_pull | output | 1 | 1 = drive the data line low, 0 = release it |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of every run |
| bus_err | output | 1 | Result of the last run: 1 = bus could not be freed |

## Verification
The assertions check, on every cycle, the properties that hold regardless of what the target does:

- `done` is a single pulse and never coincides with `busy`;
- the data line is only pulled while the clock line is released;
- the pulse count never exceeds its bound;
- a start seen during a run never rewinds the poll or pulse counters.

Only the bench scenarios, which use a target model holding the lines for a chosen time, can show the rest: the stuck-clock timeout and its timing, the late clock release, that the pulse count tracks how long the target holds data (including the exact-limit and one-beyond cases), and the START/STOP hold lengths.

// File: rtl/bus_unstick_pkg.sv
package bus_unstick_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CLK,
    ST_PROBE,
    ST_CLK_LO,
    ST_CLK_HI,
    ST_HOLD_START,
    ST_HOLD_STOP
  } unstick_state_e;

  // cycles spanned by a delay given in microseconds
  function automatic int cycles_for(input int cyc_per_us, input int usec);
    return cyc_per_us * usec;
  endfunction

  // number of clock-line samples taken before giving up (ceiling division)
  function automatic int poll_slots(input int limit_us, input int poll_us);
    return (limit_us + poll_us - 1) / poll_us;
  endfunction

  // counter width able to hold values 0..maxval
  function automatic int width_for(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  output logic [W-1:0] synced
);
  // idle bus lines float high, so both stages reset to 1
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, out_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b1;
        out_q  <= 1'b1;
      end else begin
        meta_q <= raw[g];
        out_q  <= meta_q;
      end
    end
    assign synced[g] = out_q;
  end
endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= load_val;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/bus_unstick.sv
module bus_unstick
  import bus_unstick_pkg::*;
#(
  parameter int CYC_PER_US = 50,
  parameter int POLL_US    = 500,
  parameter int LIMIT_US   = 40000,
  parameter int HALF_US    = 5,
  parameter int MAX_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull,
  output logic sda_pull,
  output logic busy,
  output logic done,
  output logic bus_err
);
  localparam int POLL_CYC = cycles_for(CYC_PER_US, POLL_US);
  localparam int HALF_CYC = cycles_for(CYC_PER_US, HALF_US);
  localparam int NPOLL    = poll_slots(LIMIT_US, POLL_US);
  localparam int CW       = width_for((POLL_CYC > HALF_CYC) ? POLL_CYC : HALF_CYC);
  localparam int PW       = width_for(MAX_PULSES);
  localparam int NW       = width_for(NPOLL);

  unstick_state_e state_q, state_d;
  logic [PW-1:0]  pulse_q;
  logic [NW-1:0]  poll_q;
  logic           done_q, err_q;

  // synchronized line levels
  logic [1:0] lines_s;
  logic       scl_s, sda_s;

  line_sync #(.W(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    ({scl_in, sda_in}),
    .synced (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  // phase timer
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  dwell_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  // named internal events
  logic accept, poll_due, clk_seen, polls_exhausted;
  logic data_free, pulses_exhausted, pulse_inc, poll_inc, finish, fail;

  assign accept           = (state_q == ST_IDLE) && start;
  assign poll_due         = (state_q == ST_WAIT_CLK) && tmr_zero;
  assign clk_seen         = poll_due && scl_s;
  assign polls_exhausted  = (poll_q == NW'(NPOLL - 1));
  assign data_free        = (state_q == ST_PROBE) && sda_s;
  assign pulses_exhausted = (pulse_q == PW'(MAX_PULSES));

  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    pulse_inc = 1'b0;
    poll_inc  = 1'b0;
    finish    = 1'b0;
    fail      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_WAIT_CLK;
        tmr_load = 1'b1;
      end
      ST_WAIT_CLK: if (tmr_zero) begin
        if (scl_s) begin
          state_d = ST_PROBE;
        end else if (polls_exhausted) begin
          fail = 1'b1;
        end else begin
          poll_inc = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CW'(POLL_CYC - 1);
        end
      end
      ST_PROBE: begin
        if (sda_s) begin
          state_d  = ST_HOLD_START;
          tmr_load = 1'b1;
          tmr_val  = CW'(HALF_CYC - 1);
        end else if (pulses_exhausted) begin
          fail = 1'b1;
        end else begin
          state_d  = ST_CLK_LO;
          tmr_load = 1'b1;
          tmr_val  = CW'(HALF_CYC - 1);
        end
      end
      ST_CLK_LO: if (tmr_zero) begin
        state_d  = ST_CLK_HI;
        tmr_load = 1'b1;
        tmr_val  = CW'(HALF_CYC - 1);
      end
      ST_CLK_HI: if (tmr_zero) begin
        state_d   = ST_PROBE;
        pulse_inc = 1'b1;
      end
      ST_HOLD_START: if (tmr_zero) begin
        state_d  = ST_HOLD_STOP;
        tmr_load = 1'b1;
        tmr_val  = CW'(HALF_CYC - 1);
      end
      ST_HOLD_STOP: if (tmr_zero) finish = 1'b1;
      default: state_d = ST_IDLE;
    endcase
    if (fail || finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      poll_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fail || finish;
      if (accept) begin
        pulse_q <= '0;
        poll_q  <= '0;
        err_q   <= 1'b0;
      end else begin
        if (pulse_inc) pulse_q <= pulse_q + 1'b1;
        if (poll_inc)  poll_q  <= poll_q + 1'b1;
        if (fail)      err_q   <= 1'b1;
      end
    end
  end

  assign scl_pull = (state_q == ST_CLK_LO);
  assign sda_pull = (state_q == ST_HOLD_START);
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign bus_err  = err_q;

  // ---------------- assertions ----------------
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_under_high_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> !scl_pull);

  assert_pulse_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PW'(MAX_PULSES));

  assert_no_start_after_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROBE && pulses_exhausted && !data_free) |=> !sda_pull);

  assert_busy_ignores_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (pulse_q >= $past(pulse_q) && poll_q >= $past(poll_q)));

  assert_poll_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q <= NW'(NPOLL - 1));

endmodule

// File: tb/bus_unstick_tb_top.sv
module bus_unstick_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPU   = 2;
  localparam int POLL  = 10;
  localparam int LIMIT = 80;
  localparam int HALF  = 3;
  localparam int MAXP  = 9;
  localparam int P     = CPU * POLL;                 // cycles between samples
  localparam int N     = (LIMIT + POLL - 1) / POLL;  // samples in all
  localparam int H     = CPU * HALF;                 // half-period cycles

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl_pull, sda_pull, busy, done, bus_err;
  logic scl_line, sda_line;

  // target model
  logic tgt_scl_low = 1'b0;
  int   k_target = 0;

  // monitors
  logic mon_clr = 1'b0;
  int pulses = 0, falls = 0, lo_run = 0, bad_low = 0;
  int sda_cyc = 0, overlap = 0;
  logic prev_scl = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit summarized = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !(scl_pull || tgt_scl_low);
  assign sda_line = !(sda_pull || (falls < k_target));

  bus_unstick #(
    .CYC_PER_US(CPU), .POLL_US(POLL), .LIMIT_US(LIMIT),
    .HALF_US(HALF), .MAX_PULSES(MAXP)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull(scl_pull), .sda_pull(sda_pull),
    .busy(busy), .done(done), .bus_err(bus_err)
  );

  always @(negedge clk) begin
    if (mon_clr) begin
      pulses = 0; falls = 0; lo_run = 0; bad_low = 0;
      sda_cyc = 0; overlap = 0; prev_scl = 1'b0;
    end else begin
      if (scl_pull) lo_run++;
      if (scl_pull && !prev_scl) pulses++;
      if (!scl_pull && prev_scl) begin
        falls++;
        if (lo_run != H) bad_low++;
        lo_run = 0;
      end
      if (sda_pull) sda_cyc++;
      if (sda_pull && scl_pull) overlap++;
      prev_scl = scl_pull;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!summarized) begin
      summarized = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // one run: clear monitors, pulse start, wait for done
  task automatic launch(output int cyc, output logic err);
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    cyc = 0;
    err = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check(busy === 1'b1, "R2 busy after start", int'(busy), 1);
      if (done === 1'b1) begin
        err = bus_err;
        check(busy === 1'b0, "R9 busy low with done", int'(busy), 0);
        break;
      end
      if (cyc > 3000) begin
        check(1'b0, "R9 done never seen", cyc, 0);
        break;
      end
    end
    @(negedge clk);
    check(done === 1'b0, "R9 done one cycle", int'(done), 0);
    check(bus_err === err, "R9 bus_err held", int'(bus_err), int'(err));
  endtask

  task automatic t_reset();
    check({scl_pull, sda_pull, busy, done, bus_err} === 5'b0, "R1 reset outputs",
          int'({scl_pull, sda_pull, busy, done, bus_err}), 0);
  endtask

  task automatic t_stuck_clock();
    int cyc; logic err;
    tgt_scl_low = 1'b1; k_target = 0;
    launch(cyc, err);
    check(err === 1'b1, "R3 stuck clock error", int'(err), 1);
    check(cyc >= 2 + (N-1)*P && cyc <= 6 + (N-1)*P, "R3 timeout length", cyc, 2 + (N-1)*P);
    check(pulses == 0, "R3 no clocks on timeout", pulses, 0);
    check(sda_cyc == 0, "R3 no START on timeout", sda_cyc, 0);
    repeat (20) @(negedge clk);
    check(bus_err === 1'b1, "R9 error held after run", int'(bus_err), 1);
    tgt_scl_low = 1'b0;
  endtask

  task automatic t_late_clock();
    int cyc; logic err;
    tgt_scl_low = 1'b1; k_target = 0;
    fork
      launch(cyc, err);
      begin
        repeat (50) @(posedge clk);
        #1 tgt_scl_low = 1'b0;
      end
    join
    check(err === 1'b0, "R4 late clock recovers", int'(err), 0);
    check(cyc > 50 && cyc < 2 + (N-1)*P, "R4 proceeds before limit", cyc, 60);
    check(sda_cyc == H, "R8 START hold after late clock", sda_cyc, H);
  endtask

  task automatic t_pulses(input int k, input bit exp_err);
    int cyc; logic err;
    int exp_p;
    exp_p = (k > MAXP) ? MAXP : k;
    k_target = k;
    launch(cyc, err);
    check(err === exp_err, "R5/R7 result", int'(err), int'(exp_err));
    check(pulses == exp_p, "R5 pulse count", pulses, exp_p);
    check(bad_low == 0, "R6 low phase length", bad_low, 0);
    check(overlap == 0, "R8 SDA only pulled with SCL released", overlap, 0);
    if (exp_err)
      check(sda_cyc == 0, "R7 no START after failure", sda_cyc, 0);
    else
      check(sda_cyc == H, "R8 START hold length", sda_cyc, H);
    k_target = 0;
  endtask

  task automatic t_start_ignored();
    int cyc; logic err;
    int extra_done;
    tgt_scl_low = 1'b1; k_target = 0;
    fork
      launch(cyc, err);
      begin
        repeat (25) @(posedge clk);
        for (int i = 0; i < 3; i++) begin
          #1 start = 1'b1;
          @(posedge clk); #1 start = 1'b0;
          repeat (20) @(posedge clk);
        end
      end
    join
    check(cyc >= 2 + (N-1)*P && cyc <= 6 + (N-1)*P, "R10 run length unchanged", cyc, 2 + (N-1)*P);
    check(err === 1'b1, "R10 result unchanged", int'(err), 1);
    extra_done = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (done === 1'b1) extra_done++;
    end
    check(extra_done == 0 && busy === 1'b0, "R10 single done, idle after", extra_done, 0);
    tgt_scl_low = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stuck_clock();
    t_pulses(0, 1'b0);   // also shows R9: error cleared by a new run
    t_late_clock();
    t_pulses(3, 1'b0);
    t_pulses(MAXP, 1'b0);
    t_pulses(MAXP + 1, 1'b1);
    t_pulses(1, 1'b0);
    t_start_ignored();
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end
endmodule